// File: doc/BRIEF.md
# Latch-Coded Serial Frame Writer

This block moves one full frame of grayscale data into a chain of multiplexed LED driver chips over a three-wire link: a shift clock, a serial data line and a latch line. The drivers tell commands apart by counting the shift-clock rising edges that occur while the latch line is high. One edge with the latch high stores the LED word just shifted in. Three edges make the frame-sync command.

The drivers keep refreshing the LEDs from their own memory, so the host only starts an upload when the picture has changed. The host pulses `frame_changed` once. The block then reads every 16-bit color word from a frame buffer with one cycle of read latency, in ascending address order. It shifts each word out MSB first. After the last word of every LED (three colors) it raises the latch for that word's final bit. After the last LED it leaves one quiet slot and then issues the frame-sync command. `busy` covers the whole upload.

A frame holds `LINES` multiplexed lines with `LEDS` RGB LEDs on each line, so it has `LINES*LEDS*COLORS` words in total. The shift clock runs at the system clock divided by the even parameter `SCK_DIV`, which must be at least 2.

Top module: `ledchain_frame_writer`

## Requirements
- R1: While reset is held and right after it is released, `ser_clk`, `ser_lat`, `ser_data`, `busy` and `fb_addr` are all low.
- R2: A `frame_changed` pulse seen while idle makes `busy` high from the next clock. `busy` stays high until the clock edge on which the frame-sync latch falls, and it goes low on that same edge.
- R3: The block reads frame-buffer words in ascending address order, 0 to `LINES*LEDS*COLORS-1`. It shifts each word out MSB first, one bit per shift-clock rising edge, so each LED carries exactly `16*COLORS` bits, with the lowest-addressed word first.
- R4: `ser_data` and `ser_lat` change only while `ser_clk` is low, which is at the falling edge of the shift clock. They hold steady for the whole high phase.
- R5: After every group of `COLORS` consecutive words, `ser_lat` is high for exactly one shift-clock rising edge: the one that clocks in that group's final bit.
- R6: After the final LED word, one shift period passes with no shift-clock pulse and the latch low. Then `ser_lat` is high for exactly 3 rising edges while `ser_data` stays 0.
- R7: A `frame_changed` pulse that arrives while `busy` is high has no effect: the upload gives exactly `LINES*LEDS*COLORS*16+3` rising edges, and no second upload follows.
- R8: Each shift-clock pulse is high for `SCK_DIV/2` system clocks, and a shift period lasts `SCK_DIV` system clocks.
- R9: While `busy` is low, `ser_clk` and `ser_lat` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_changed | input | 1 | Single-cycle strobe that starts one frame upload |
| fb_addr | output | $clog2(LINES*LEDS*COLORS) | Frame-buffer read address |
| fb_data | input | GS_W | Frame-buffer read data, valid one clock after the address |
| ser_clk | output | 1 | Serial shift clock to the driver chain |
| ser_data | output | 1 | Serial data, MSB first |
| ser_lat | output | 1 | Latch line; its high length in shift-clock edges encodes the command |
| busy | output | 1 | High while an upload is in progress |

## Verification
The hardest cases to reach from the ports are the two that leave only a timing trace. One is a start strobe that lands in the middle of an upload. The other is the quiet slot that separates the last data latch from the sync command. The bench fires a second strobe about a hundred clocks into selected frames and then counts every shift-clock edge of that upload against the exact total. A monitor decodes the stream the way a driver would: it counts latch-high edges and the bits shifted since the previous command. A stray pulse in the gap would show up as a 4-bit sync tail, and a restarted upload would show up as extra edges or unexpected latch events.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_LOAD,
      ST_DATA,
      ST_GAP,
      ST_SYNC
   } wr_state_e;

   // latch-high edge counts that select the driver command
   localparam int unsigned DLATCH_EDGES = 1;
   localparam int unsigned SYNC_EDGES   = 3;

endpackage

// File: rtl/lfw_sck_gen.sv
module lfw_sck_gen #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bit_end,
   output logic phase_hi
);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("lfw_sck_gen: DIV must be even and at least 2");
      end

      if (DIV == 2) begin : g_toggle
         logic tgl;
         always_ff @(posedge clk) begin
            if (!rst_n)    tgl <= 1'b0;
            else if (!run) tgl <= 1'b0;
            else           tgl <= ~tgl;
         end
         assign bit_end  = run && tgl;
         assign phase_hi = run && tgl;
      end else begin : g_count
         localparam int unsigned CW   = $clog2(DIV);
         localparam int unsigned HALF = DIV / 2;
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                      cnt <= '0;
            else if (!run)                   cnt <= '0;
            else if (cnt == CW'(DIV - 1))    cnt <= '0;
            else                             cnt <= cnt + 1'b1;
         end
         assign bit_end  = run && (cnt == CW'(DIV - 1));
         assign phase_hi = run && (cnt >= CW'(HALF));
      end
   endgenerate

   // a period always closes inside its high half
   assert_end_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |-> phase_hi);

endmodule

// File: rtl/lfw_shifter.sv
module lfw_shifter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         msb,
   output logic         last_bit
);

   localparam int unsigned BW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("lfw_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  sr;
   logic [BW-1:0] bidx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         bidx <= '0;
      end else if (load) begin
         sr   <= din;
         bidx <= '0;
      end else if (shift) begin
         sr   <= {sr[W-2:0], 1'b0};
         bidx <= bidx + 1'b1;
      end
   end

   assign msb      = sr[W-1];
   assign last_bit = (bidx == BW'(W - 1));

   // the sequencer must reload, never shift, once the final bit is out
   assert_no_shift_past_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !last_bit);

endmodule

// File: rtl/lfw_sequencer.sv
module lfw_sequencer
   import lfw_pkg::*;
#(
   parameter int unsigned WORDS  = 1536,
   parameter int unsigned COLORS = 3,
   parameter int unsigned AW     = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          bit_end,
   input  logic          last_bit,
   output logic          load,
   output logic          shift,
   output logic [AW-1:0] rd_addr,
   output logic          run,
   output logic          pulse_en,
   output logic          data_en,
   output logic          lat,
   output logic          busy
);

   localparam int unsigned CLW = (COLORS > 1) ? $clog2(COLORS) : 1;

   wr_state_e      state;
   logic [AW-1:0]  word_idx;
   logic [CLW-1:0] col;
   logic [1:0]     sync_cnt;
   logic           last_word;
   logic           word_done;

   assign last_word = (word_idx == AW'(WORDS - 1));
   assign word_done = (state == ST_DATA) && bit_end && last_bit;

   always_comb begin
      run      = (state == ST_DATA) || (state == ST_GAP) || (state == ST_SYNC);
      pulse_en = (state == ST_DATA) || (state == ST_SYNC);
      data_en  = (state == ST_DATA);
      busy     = (state != ST_IDLE);
      lat      = ((state == ST_DATA) && (col == CLW'(COLORS - 1)) && last_bit)
               || (state == ST_SYNC);
      load     = (state == ST_LOAD) || (word_done && !last_word);
      shift    = (state == ST_DATA) && bit_end && !last_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         word_idx <= '0;
         col      <= '0;
         sync_cnt <= '0;
         rd_addr  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_WAIT;
                  rd_addr <= '0;
               end
            end
            ST_WAIT: state <= ST_LOAD;
            ST_LOAD: begin
               state    <= ST_DATA;
               word_idx <= '0;
               col      <= '0;
               rd_addr  <= AW'(WORDS > 1);
            end
            ST_DATA: begin
               if (word_done) begin
                  if (last_word) begin
                     state <= ST_GAP;
                  end else begin
                     word_idx <= word_idx + 1'b1;
                     col      <= (col == CLW'(COLORS - 1)) ? '0 : col + 1'b1;
                     if (rd_addr != AW'(WORDS - 1)) rd_addr <= rd_addr + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (bit_end) begin
                  state    <= ST_SYNC;
                  sync_cnt <= '0;
               end
            end
            ST_SYNC: begin
               if (bit_end) begin
                  if (sync_cnt == 2'(SYNC_EDGES - 1)) begin
                     state   <= ST_IDLE;
                     rd_addr <= '0;
                  end else begin
                     sync_cnt <= sync_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // a strobe during an upload must not restart the fetch
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (state != ST_WAIT));

   // the gap slot never carries a latch
   assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> !lat);

endmodule

// File: rtl/ledchain_frame_writer.sv
module ledchain_frame_writer
   import lfw_pkg::*;
#(
   parameter int unsigned GS_W    = 16,
   parameter int unsigned LINES   = 32,
   parameter int unsigned LEDS    = 16,
   parameter int unsigned COLORS  = 3,
   parameter int unsigned SCK_DIV = 2,
   localparam int unsigned WORDS  = LINES * LEDS * COLORS,
   localparam int unsigned AW     = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_changed,
   output logic [AW-1:0]   fb_addr,
   input  logic [GS_W-1:0] fb_data,
   output logic            ser_clk,
   output logic            ser_data,
   output logic            ser_lat,
   output logic            busy
);

   generate
      if (WORDS < 2) begin : g_bad_words
         $error("ledchain_frame_writer: frame must hold at least two words");
      end
   endgenerate

   logic run, bit_end, phase_hi;
   logic load, shift, msb, last_bit;
   logic pulse_en, data_en;

   lfw_sck_gen #(.DIV(SCK_DIV)) u_sck (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .bit_end  (bit_end),
      .phase_hi (phase_hi)
   );

   lfw_shifter #(.W(GS_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .shift    (shift),
      .din      (fb_data),
      .msb      (msb),
      .last_bit (last_bit)
   );

   lfw_sequencer #(.WORDS(WORDS), .COLORS(COLORS), .AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (frame_changed),
      .bit_end  (bit_end),
      .last_bit (last_bit),
      .load     (load),
      .shift    (shift),
      .rd_addr  (fb_addr),
      .run      (run),
      .pulse_en (pulse_en),
      .data_en  (data_en),
      .lat      (ser_lat),
      .busy     (busy)
   );

   assign ser_clk  = phase_hi && pulse_en;
   assign ser_data = data_en && msb;

   // data and latch hold still across every high phase
   assert_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> ($stable(ser_data) && $stable(ser_lat)));

   // the latch only rises while the shift clock is low
   assert_lat_rise_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_lat) |-> !ser_clk);

   // nothing moves on the link while idle
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_lat));

   // the upload ends exactly as the sync latch drops
   assert_sync_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(ser_lat));

endmodule

// File: tb/ledchain_frame_writer_tb.sv
module ledchain_frame_writer_tb;

   localparam int GS_W     = 16;
   localparam int LINES    = 2;
   localparam int LEDS     = 2;
   localparam int COLORS   = 3;
   localparam int DIV      = 4;
   localparam int WORDS    = LINES * LEDS * COLORS;
   localparam int AW       = $clog2(WORDS);
   localparam int LED_BITS = GS_W * COLORS;
   localparam int EDGES    = WORDS * GS_W + 3;
   localparam int HALF_PS  = 2500;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            frame_changed = 1'b0;
   logic [AW-1:0]   fb_addr;
   logic [GS_W-1:0] fb_data = '0;
   logic            ser_clk, ser_data, ser_lat, busy;
   logic [GS_W-1:0] fb_mem [WORDS];

   always #HALF_PS clk = ~clk;

   always_ff @(posedge clk) fb_data <= fb_mem[fb_addr];

   ledchain_frame_writer #(
      .GS_W(GS_W), .LINES(LINES), .LEDS(LEDS), .COLORS(COLORS), .SCK_DIV(DIV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_changed(frame_changed),
      .fb_addr(fb_addr), .fb_data(fb_data),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_lat(ser_lat), .busy(busy)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [LED_BITS:0] exp_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- monitor: decodes the link like a driver chip
   logic p_sclk = 1'b0, p_lat = 1'b0, p_sdo = 1'b0;
   logic [LED_BITS-1:0] acc = '0;
   int lat_edges = 0, since = 0, hi_len = 0, frame_edges = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!busy && (ser_clk || ser_lat))
            check(1'b0, "R9", "link active while idle", {ser_clk, ser_lat}, 0);
         if (ser_clk && p_sclk && (ser_data != p_sdo || ser_lat != p_lat))
            check(1'b0, "R4", "data/latch moved in high phase", {ser_data, ser_lat}, {p_sdo, p_lat});
         if (ser_clk && !p_sclk) begin
            acc = {acc[LED_BITS-2:0], ser_data};
            since++;
            frame_edges++;
            if (ser_lat) lat_edges++;
            hi_len = 1;
         end else if (ser_clk) begin
            hi_len++;
         end
         if (!ser_clk && p_sclk)
            check(hi_len == DIV / 2, "R8", "shift clock high length", hi_len, DIV / 2);
         if (!ser_lat && p_lat) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7", "unexpected latch command", lat_edges, 0);
            end else begin
               logic [LED_BITS:0] e;
               e = exp_q.pop_front();
               if (e[LED_BITS]) begin
                  check(lat_edges == 3, "R6", "sync latch edges", lat_edges, 3);
                  check(since == 3, "R6", "edges since last latch (gap pulse?)", since, 3);
                  check(acc[2:0] == 3'b000, "R6", "data during sync", acc[2:0], 0);
                  check(!busy, "R2", "busy when sync ends", busy, 0);
               end else begin
                  check(lat_edges == 1, "R5", "data latch edges", lat_edges, 1);
                  check(since == LED_BITS, "R3", "bits per LED word", since, LED_BITS);
                  check(acc == e[LED_BITS-1:0], "R3", "LED word content", acc, e[LED_BITS-1:0]);
               end
            end
            lat_edges = 0;
            since     = 0;
         end
      end
      p_sclk = ser_clk;
      p_lat  = ser_lat;
      p_sdo  = ser_data;
   end

   // ---------------- driver: loads the buffer, queues the expected commands
   task automatic run_frame(input int pat, input bit extra_start);
      for (int i = 0; i < WORDS; i++) begin
         case (pat)
            0:       fb_mem[i] = GS_W'(16'h0101 * (i + 1));
            1:       fb_mem[i] = '1;
            2:       fb_mem[i] = (i % 2 == 0) ? GS_W'(16'hA5A5) : GS_W'(16'h5A5A);
            default: fb_mem[i] = GS_W'($urandom);
         endcase
      end
      for (int l = 0; l < LINES * LEDS; l++)
         exp_q.push_back({1'b0, fb_mem[3*l], fb_mem[3*l+1], fb_mem[3*l+2]});
      exp_q.push_back({1'b1, {LED_BITS{1'b0}}});
      frame_edges = 0;
      @(negedge clk) frame_changed = 1'b1;
      @(negedge clk) frame_changed = 1'b0;
      check(busy == 1'b1, "R2", "busy after start strobe", busy, 1);
      if (extra_start) begin
         repeat (100) @(negedge clk);
         frame_changed = 1'b1;
         @(negedge clk) frame_changed = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (40) @(negedge clk);
      check(!busy, "R7", "no second upload after extra strobe", busy, 0);
      check(frame_edges == EDGES, "R7", "shift edges in upload", frame_edges, EDGES);
      check(exp_q.size() == 0, "R3", "commands left unsent", exp_q.size(), 0);
      check(!ser_clk && !ser_lat && fb_addr == '0, "R9", "idle link after upload",
            {ser_clk, ser_lat, fb_addr}, 0);
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) fb_mem[i] = '0;
      repeat (5) @(negedge clk);
      check(!ser_clk && !ser_lat && !ser_data && !busy && fb_addr == '0, "R1",
            "outputs in reset", {ser_clk, ser_lat, ser_data, busy, fb_addr}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!ser_clk && !ser_lat && !ser_data && !busy && fb_addr == '0, "R1",
            "outputs after reset", {ser_clk, ser_lat, ser_data, busy, fb_addr}, 0);
      run_frame(0, 1'b0);
      run_frame(1, 1'b1);
      run_frame(2, 1'b0);
      run_frame(3, 1'b1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: actual busy %0d expected upload to finish", busy);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule